// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the purely combinational front of a single-cycle processor for a small teaching instruction set. Each instruction is 1, 2, 5 or 6 bytes long. Every cycle the fetch stage reads a fixed six-byte window from instruction memory at the current program counter. The block takes that window and the program counter and splits out the opcode class and the function code. It also works out whether a register-specifier byte and a four-byte constant follow the opcode, extracts the two register fields and the constant, and produces the address of the next sequential instruction.

The window is packed with byte k of memory (address pc + k) on bits `[8k+7:8k]`. The class code selects two presence flags. The instruction length follows from those two flags alone, as one byte for the opcode, plus one for a register byte, plus four for a constant. The constant starts right after the opcode, or one byte later when a register byte is present. Class codes outside the supported set are flagged as illegal and treated as one byte long. Instruction memory, the register file, execution and the program counter register itself are outside this block.

No states or transitions exist. The block is combinational and the same decoding applies on every evaluation.

Top module: `fetch_decoder`

## Requirements
- R1: `icode_o` equals bits [7:4] of window byte 0 (window bits [7:4]) and `ifun_o` equals bits [3:0] of that byte, for every window.
- R2: `has_regs_o` is 1 exactly for class codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. `has_const_o` is 1 exactly for class codes 0x3, 0x4, 0x5, 0x7 and 0x8.
- R3: `next_pc_o` equals `pc_i` + 1 + `has_regs_o` + 4·`has_const_o`, taken modulo 2^32, so the address wraps past 0xFFFFFFFF.
- R4: When `has_regs_o` is 1, `rega_o` is bits [7:4] and `regb_o` is bits [3:0] of window byte 1. When `has_regs_o` is 0, both equal the no-register code 0xF.
- R5: `const_o` is assembled little-endian from window bytes 1 to 4 when `has_regs_o` is 0. It is assembled from bytes 2 to 5 when `has_regs_o` is 1. The lowest-numbered byte goes to bits [7:0].
- R6: For class codes 0xC to 0xF, `bad_op_o` is 1, both presence flags are 0 and the length is 1. For codes 0x0 to 0xB, `bad_op_o` is 0.
- R7: The function code never changes the presence flags or the length. The ALU class 0x6 is 2 bytes long, the conditional-branch class 0x7 is 5 bytes and the register-to-memory store class 0x4 is 6 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the instruction being fetched |
| window_i | input | 48 | Six bytes read from memory at pc_i; byte k on bits [8k+7:8k] |
| icode_o | output | 4 | Opcode class code |
| ifun_o | output | 4 | Function code |
| rega_o | output | 4 | First register specifier, 0xF when absent |
| regb_o | output | 4 | Second register specifier, 0xF when absent |
| const_o | output | 32 | Four-byte constant, little-endian |
| has_regs_o | output | 1 | A register byte follows the opcode |
| has_const_o | output | 1 | A four-byte constant is present |
| bad_op_o | output | 1 | Class code is not supported |
| next_pc_o | output | 32 | pc_i plus the instruction length |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a six-byte window and a four-byte constant. Those defaults make the longest instruction fill the window exactly, so both constant positions are exercised at the window's edge. The 16 class codes are small enough to sweep every one against every function code. Each pairing is applied with four byte patterns and four program counters, one of which sits two bytes below the top of the address space and forces the 5- and 6-byte lengths to wrap.

// File: rtl/fd_pkg.sv
package fd_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = 4;

    // Supported opcode classes; codes 0xC..0xF are illegal
    typedef enum logic [3:0] {
        CLS_STOP    = 4'h0,
        CLS_IDLE    = 4'h1,
        CLS_MOVRR   = 4'h2,
        CLS_LDIMM   = 4'h3,
        CLS_STORE   = 4'h4,
        CLS_LOAD    = 4'h5,
        CLS_ALU     = 4'h6,
        CLS_BRANCH  = 4'h7,
        CLS_CALL    = 4'h8,
        CLS_RETURN  = 4'h9,
        CLS_PUSH    = 4'hA,
        CLS_POP     = 4'hB
    } iclass_e;

    typedef struct packed {
        logic has_regs;
        logic has_const;
        logic bad;
    } cls_flags_t;

    localparam logic [NIB_W-1:0] NO_REG = 4'hF;

endpackage

// File: rtl/fd_class_decode.sv
module fd_class_decode
    import fd_pkg::*;
(
    input  logic [NIB_W-1:0] code_i,
    output cls_flags_t       flags_o
);

    always_comb begin
        flags_o = '{has_regs: 1'b0, has_const: 1'b0, bad: 1'b0};
        unique case (code_i)
            CLS_STOP, CLS_IDLE, CLS_RETURN: ;
            CLS_MOVRR, CLS_ALU, CLS_PUSH, CLS_POP:
                flags_o.has_regs = 1'b1;
            CLS_LDIMM, CLS_STORE, CLS_LOAD: begin
                flags_o.has_regs  = 1'b1;
                flags_o.has_const = 1'b1;
            end
            CLS_BRANCH, CLS_CALL:
                flags_o.has_const = 1'b1;
            default:
                flags_o.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/fd_field_extract.sv
module fd_field_extract
    import fd_pkg::*;
#(
    parameter int unsigned WIN_BYTES   = 6,
    parameter int unsigned CONST_BYTES = 4
) (
    // window bytes 1 .. WIN_BYTES-1 (byte 0 handled by the caller)
    input  logic [(WIN_BYTES-1)*BYTE_W-1:0] tail_i,
    input  logic                            has_regs_i,
    output logic [NIB_W-1:0]                ra_o,
    output logic [NIB_W-1:0]                rb_o,
    output logic [CONST_BYTES*BYTE_W-1:0]   const_o
);

    localparam int unsigned TAIL_BYTES = WIN_BYTES - 1;

    // tail byte j holds window byte j+1
    always_comb begin
        if (has_regs_i) begin
            ra_o = tail_i[BYTE_W-1 -: NIB_W];
            rb_o = tail_i[NIB_W-1:0];
        end else begin
            ra_o = NO_REG;
            rb_o = NO_REG;
        end
    end

    genvar g;
    generate
        for (g = 0; g < CONST_BYTES; g++) begin : g_cbyte
            if (g + 1 < TAIL_BYTES) begin : g_shift
                assign const_o[g*BYTE_W +: BYTE_W] = has_regs_i
                    ? tail_i[(g+1)*BYTE_W +: BYTE_W]
                    : tail_i[g*BYTE_W +: BYTE_W];
            end else begin : g_edge
                assign const_o[g*BYTE_W +: BYTE_W] = has_regs_i
                    ? '0
                    : tail_i[g*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

endmodule

// File: rtl/fd_next_pc.sv
module fd_next_pc #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CONST_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              has_regs_i,
    input  logic              has_const_i,
    output logic [ADDR_W-1:0] next_pc_o
);

    localparam logic [ADDR_W-1:0] STEP_OPC   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_REGS  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_CONST = ADDR_W'(CONST_BYTES);

    logic [ADDR_W-1:0] len;

    always_comb begin
        len = STEP_OPC;
        if (has_regs_i)  len = len + STEP_REGS;
        if (has_const_i) len = len + STEP_CONST;
        next_pc_o = pc_i + len;
    end

endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
    import fd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned WIN_BYTES   = 6,
    parameter int unsigned CONST_BYTES = 4
) (
    input  logic [ADDR_W-1:0]              pc_i,
    input  logic [WIN_BYTES*BYTE_W-1:0]    window_i,
    output logic [NIB_W-1:0]               icode_o,
    output logic [NIB_W-1:0]               ifun_o,
    output logic [NIB_W-1:0]               rega_o,
    output logic [NIB_W-1:0]               regb_o,
    output logic [CONST_BYTES*BYTE_W-1:0]  const_o,
    output logic                           has_regs_o,
    output logic                           has_const_o,
    output logic                           bad_op_o,
    output logic [ADDR_W-1:0]              next_pc_o
);

    localparam int unsigned WIN_W = WIN_BYTES * BYTE_W;

    cls_flags_t flags;

    assign icode_o = window_i[BYTE_W-1 -: NIB_W];
    assign ifun_o  = window_i[NIB_W-1:0];

    fd_class_decode u_cls (
        .code_i  (icode_o),
        .flags_o (flags)
    );

    assign has_regs_o  = flags.has_regs;
    assign has_const_o = flags.has_const;
    assign bad_op_o    = flags.bad;

    fd_field_extract #(
        .WIN_BYTES   (WIN_BYTES),
        .CONST_BYTES (CONST_BYTES)
    ) u_fld (
        .tail_i     (window_i[WIN_W-1:BYTE_W]),
        .has_regs_i (flags.has_regs),
        .ra_o       (rega_o),
        .rb_o       (regb_o),
        .const_o    (const_o)
    );

    fd_next_pc #(
        .ADDR_W      (ADDR_W),
        .CONST_BYTES (CONST_BYTES)
    ) u_npc (
        .pc_i        (pc_i),
        .has_regs_i  (flags.has_regs),
        .has_const_i (flags.has_const),
        .next_pc_o   (next_pc_o)
    );

endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned WIN_BYTES   = 6,
    parameter int unsigned CONST_BYTES = 4
) (
    input logic [ADDR_W-1:0]           pc_i,
    input logic [WIN_BYTES*8-1:0]      window_i,
    input logic [3:0]                  icode_o,
    input logic [3:0]                  ifun_o,
    input logic [3:0]                  rega_o,
    input logic [3:0]                  regb_o,
    input logic [CONST_BYTES*8-1:0]    const_o,
    input logic                        has_regs_o,
    input logic                        has_const_o,
    input logic                        bad_op_o,
    input logic [ADDR_W-1:0]           next_pc_o
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] want_step;

    always_comb begin
        step      = next_pc_o - pc_i;
        want_step = ADDR_W'(1) + ADDR_W'(has_regs_o)
                  + (has_const_o ? ADDR_W'(CONST_BYTES) : '0);

        // R1
        split_chk: assert ({icode_o, ifun_o} == window_i[7:0])
            else $error("opcode byte split mismatch");

        // R3
        length_chk: assert (step == want_step)
            else $error("next address step %0d", step);

        // R4
        noreg_chk: assert (has_regs_o || (rega_o == 4'hF && regb_o == 4'hF))
            else $error("register fields not blank");

        // R5
        const_pos_chk: assert (has_regs_o
                ? const_o == window_i[8*(CONST_BYTES+2)-1:16]
                : const_o == window_i[8*(CONST_BYTES+1)-1:8])
            else $error("constant taken from wrong bytes");

        // R6
        illegal_chk: assert (bad_op_o == (icode_o >= 4'hC)
                && (!bad_op_o || (!has_regs_o && !has_const_o)))
            else $error("illegal class handling");
    end

endmodule

bind fetch_decoder fd_checker #(
    .ADDR_W      (ADDR_W),
    .WIN_BYTES   (WIN_BYTES),
    .CONST_BYTES (CONST_BYTES)
) u_chk (
    .pc_i        (pc_i),
    .window_i    (window_i),
    .icode_o     (icode_o),
    .ifun_o      (ifun_o),
    .rega_o      (rega_o),
    .regb_o      (regb_o),
    .const_o     (const_o),
    .has_regs_o  (has_regs_o),
    .has_const_o (has_const_o),
    .bad_op_o    (bad_op_o),
    .next_pc_o   (next_pc_o)
);

// File: tb/sim_fetch_decoder.sv
module sim_fetch_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc;
    logic [47:0] win;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] cval, npc;
    logic        hreg, hcst, bad;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    fetch_decoder u0 (
        .pc_i        (pc),
        .window_i    (win),
        .icode_o     (icode),
        .ifun_o      (ifun),
        .rega_o      (ra),
        .regb_o      (rb),
        .const_o     (cval),
        .has_regs_o  (hreg),
        .has_const_o (hcst),
        .bad_op_o    (bad),
        .next_pc_o   (npc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h (window %h pc %h)", req, act, exp, win, pc);
        end
    endtask

    function automatic logic [7:0] pat(input int c, input int f, input int p, input int k);
        return 8'((c * 37 + f * 11 + p * 73 + k * 29 + 5) & 255);
    endfunction

    task automatic one(input int c, input int f, input int p);
        logic [7:0]  b [6];
        logic [31:0] pcv;
        logic        er, ec, eb;
        logic [31:0] len;
        @(posedge clk);
        b[0] = 8'((c << 4) | f);
        for (int k = 1; k < 6; k++) b[k] = pat(c, f, p, k);
        case (p)
            0:       pcv = 32'h0000_0000;
            1:       pcv = 32'hFFFF_FFFE;
            2:       pcv = 32'h0000_1000;
            default: pcv = 32'(c * 32'h0101_0107 + f * 32'h0003_0011 + 32'h7654_3210);
        endcase
        pc  = pcv;
        win = {b[5], b[4], b[3], b[2], b[1], b[0]};
        er  = (c >= 2 && c <= 6) || c == 10 || c == 11;
        ec  = (c >= 3 && c <= 5) || c == 7 || c == 8;
        eb  = c >= 12;
        len = 32'(1 + (er ? 1 : 0) + (ec ? 4 : 0));
        @(negedge clk);
        chk("R1 icode", {28'd0, icode}, 32'(c));
        chk("R1 ifun",  {28'd0, ifun},  32'(f));
        chk("R2 has_regs",  {31'd0, hreg}, {31'd0, er});
        chk("R2 has_const", {31'd0, hcst}, {31'd0, ec});
        chk("R6 bad_op",    {31'd0, bad},  {31'd0, eb});
        chk("R3 next_pc", npc, pcv + len);
        chk("R4 rega", {28'd0, ra}, er ? {28'd0, b[1][7:4]} : 32'hF);
        chk("R4 regb", {28'd0, rb}, er ? {28'd0, b[1][3:0]} : 32'hF);
        chk("R5 const", cval, er ? {b[5], b[4], b[3], b[2]} : {b[4], b[3], b[2], b[1]});
        if (eb) chk("R6 length one", npc - pcv, 32'd1);
        if (c == 6) chk("R7 alu length",    npc - pcv, 32'd2);
        if (c == 7) chk("R7 branch length", npc - pcv, 32'd5);
        if (c == 4) chk("R7 store length",  npc - pcv, 32'd6);
    endtask

    initial begin
        pc  = '0;
        win = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset-state window: all-zero stop instruction at address 0
        chk("R1 reset icode", {28'd0, icode}, 32'd0);
        chk("R3 reset next_pc", npc, 32'd1);
        chk("R4 reset rega", {28'd0, ra}, 32'hF);
        rst = 1'b0;
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                for (int p = 0; p < 4; p++)
                    one(c, f, p);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act %0d exp %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule